// File: doc/BRIEF.md
# ALU with Condition Codes and Branch Test

This block combines a 32-bit arithmetic/logic unit, a small register holding three status flags, and a branch-condition evaluator. The ALU computes one of four operations on two operands under a 2-bit function select. Subtraction takes the first operand away from the second.

The flag register captures zero, sign and overflow from the ALU result at a rising clock edge, but only when the set-flags enable is high. The flags therefore reflect the most recent arithmetic or logic instruction that was allowed to write them.

The branch evaluator is purely combinational. It reads the stored flags, not the flags of the operation currently on the ALU inputs. It decodes a 4-bit jump code into a taken/not-taken bit. Reset is asynchronous and active-low. Its release is synchronised internally over two clock edges before the flag register leaves its reset value.

Top module: `alu_cc_unit`

## Requirements
- R1: `result` is a combinational function of the inputs, selected by `alu_fn`: 0 gives op_b+op_a, 1 gives op_b-op_a, 2 gives op_b AND op_a, 3 gives op_b XOR op_a (all modulo 2^32).
- R2: At a rising edge with `set_cc`=1, `flag_zero` loads 1 exactly when `result` is zero, and `flag_sign` loads bit 31 of `result`.
- R3: For `alu_fn`=0, the captured `flag_ovf` is 1 exactly when both operands have the same bit 31 and the result's bit 31 differs from it.
- R4: For `alu_fn`=1, the captured `flag_ovf` is 1 exactly when op_a and op_b differ in bit 31 and the result's bit 31 differs from op_b's.
- R5: For `alu_fn`=2 or 3, the captured `flag_ovf` is 0.
- R6: At a rising edge with `set_cc`=0, all three flags keep their values.
- R7: While `rst_n` is low the flags read zero=1, sign=0, overflow=0. They stay so until two rising edges after `rst_n` rises.
- R8: `take_branch` depends on the stored flags and `jmp_fn`. Code 0 is always taken. Code 1 is taken on (sign^ovf)|zero. Code 2 is taken on sign^ovf. Code 3 is taken on zero. Code 4 is taken on !zero. Code 5 is taken on !(sign^ovf). Code 6 is taken on !(sign^ovf)&!zero.
- R9: For `jmp_fn` values 7 to 15, `take_branch` is 0.
- R10: In a cycle where `set_cc`=1, `take_branch` still reflects the flags held before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand (subtrahend for subtract) |
| op_b | input | 32 | Second operand |
| alu_fn | input | 2 | ALU operation select |
| set_cc | input | 1 | Flag register write enable |
| jmp_fn | input | 4 | Jump condition code |
| result | output | 32 | ALU result |
| flag_zero | output | 1 | Stored zero flag |
| flag_sign | output | 1 | Stored sign flag |
| flag_ovf | output | 1 | Stored overflow flag |
| take_branch | output | 1 | Branch condition met |

## Verification
A flag update and a branch evaluation often fall in the same cycle. In that cycle the ALU result that is about to be captured can disagree with the flags the branch reads. The bench provokes this by asserting `set_cc` on operations whose result flips zero or sign, while presenting a jump code sensitive to that flag. It then checks `take_branch` before the edge against the model's old flags and checks the flags after the edge against the new ones. Random cycles mix enable, operation and jump code so that the overlap recurs under many flag states.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_XOR = 2'd3
  } alu_op_e;

  typedef enum logic [3:0] {
    JC_ALWAYS = 4'd0,
    JC_LE     = 4'd1,
    JC_LT     = 4'd2,
    JC_EQ     = 4'd3,
    JC_NE     = 4'd4,
    JC_GE     = 4'd5,
    JC_GT     = 4'd6
  } jcond_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic ovf;
  } cc_flags_t;

  localparam cc_flags_t CC_RESET = '{zero: 1'b1, sign: 1'b0, ovf: 1'b0};
endpackage

// File: rtl/alu_cc_rst_sync.sv
module alu_cc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       alu_fn,
  output logic [WIDTH-1:0] result,
  output cc_flags_t        flags_next
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] res;
  logic             ovf;

  always_comb begin
    res = '0;
    ovf = 1'b0;
    case (alu_fn)
      ALU_ADD: begin
        res = op_b + op_a;
        ovf = (op_a[MSB] == op_b[MSB]) && (res[MSB] != op_a[MSB]);
      end
      ALU_SUB: begin
        res = op_b - op_a;
        ovf = (op_a[MSB] != op_b[MSB]) && (res[MSB] != op_b[MSB]);
      end
      ALU_AND: res = op_b & op_a;
      default: res = op_b ^ op_a;
    endcase
  end

  assign result          = res;
  assign flags_next.zero = (res == '0);
  assign flags_next.sign = res[MSB];
  assign flags_next.ovf  = ovf;
endmodule

// File: rtl/alu_cc_flag_reg.sv
module alu_cc_flag_reg
  import alu_cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_en,
  input  cc_flags_t flags_d,
  output cc_flags_t flags_q
);
  cc_flags_t flags_nxt;

  always_comb begin
    flags_nxt = flags_q;
    if (load_en) flags_nxt = flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= CC_RESET;
    else        flags_q <= flags_nxt;
  end
endmodule

// File: rtl/alu_cc_branch_eval.sv
module alu_cc_branch_eval
  import alu_cc_pkg::*;
(
  input  cc_flags_t  flags,
  input  logic [3:0] jmp_fn,
  output logic       taken
);
  logic lt;

  always_comb begin
    lt = flags.sign ^ flags.ovf;
    case (jmp_fn)
      JC_ALWAYS: taken = 1'b1;
      JC_LE:     taken = lt | flags.zero;
      JC_LT:     taken = lt;
      JC_EQ:     taken = flags.zero;
      JC_NE:     taken = !flags.zero;
      JC_GE:     taken = !lt;
      JC_GT:     taken = !lt && !flags.zero;
      default:   taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       alu_fn,
  input  logic             set_cc,
  input  logic [3:0]       jmp_fn,
  output logic [WIDTH-1:0] result,
  output logic             flag_zero,
  output logic             flag_sign,
  output logic             flag_ovf,
  output logic             take_branch
);
  logic      rst_int_n;
  cc_flags_t flags_next;
  cc_flags_t flags_cur;

  alu_cc_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  alu_cc_core #(.WIDTH(WIDTH)) core_i (
    .op_a       (op_a),
    .op_b       (op_b),
    .alu_fn     (alu_fn),
    .result     (result),
    .flags_next (flags_next)
  );

  alu_cc_flag_reg flag_reg_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (set_cc),
    .flags_d (flags_next),
    .flags_q (flags_cur)
  );

  alu_cc_branch_eval branch_i (
    .flags  (flags_cur),
    .jmp_fn (jmp_fn),
    .taken  (take_branch)
  );

  assign flag_zero = flags_cur.zero;
  assign flag_sign = flags_cur.sign;
  assign flag_ovf  = flags_cur.ovf;
endmodule

// File: rtl/alu_cc_unit_chk.sv
module alu_cc_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_int_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       alu_fn,
  input logic             set_cc,
  input logic [3:0]       jmp_fn,
  input logic [WIDTH-1:0] result,
  input logic             flag_zero,
  input logic             flag_sign,
  input logic             flag_ovf,
  input logic             take_branch
);
  localparam int MSB = WIDTH - 1;

  // R7
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_flags_chk: assert (flag_zero && !flag_sign && !flag_ovf);
    end
  end

  // R9
  always @(negedge clk) begin
    if (rst_n && jmp_fn > 4'd6) begin
      bad_code_chk: assert (!take_branch);
    end
  end

  // R8
  always @(negedge clk) begin
    if (rst_n && jmp_fn == 4'd0) begin
      always_taken_chk: assert (take_branch);
    end
  end

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(set_cc) |-> ($stable(flag_zero) && $stable(flag_sign) && $stable(flag_ovf)));

  // R2
  zero_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_cc && rst_int_n) |-> (flag_zero == ($past(result) == '0)));

  // R2
  sign_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_cc && rst_int_n) |-> (flag_sign == $past(result[MSB])));

  // R3
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_cc && rst_int_n && alu_fn == 2'd0 && op_a[MSB] == op_b[MSB]
          && result[MSB] != op_a[MSB]) |-> flag_ovf);

  // R5
  logic_ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_cc && rst_int_n && alu_fn[1]) |-> !flag_ovf);
endmodule

bind alu_cc_unit alu_cc_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_int_n   (rst_int_n),
  .op_a        (op_a),
  .op_b        (op_b),
  .alu_fn      (alu_fn),
  .set_cc      (set_cc),
  .jmp_fn      (jmp_fn),
  .result      (result),
  .flag_zero   (flag_zero),
  .flag_sign   (flag_sign),
  .flag_ovf    (flag_ovf),
  .take_branch (take_branch)
);

// File: tb/alu_cc_unit_tb_top.sv
module alu_cc_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [1:0]  alu_fn;
  logic        set_cc;
  logic [3:0]  jmp_fn;
  logic [31:0] result;
  logic        flag_zero, flag_sign, flag_ovf, take_branch;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference state
  bit m_z, m_s, m_o;
  bit p_z, p_s, p_o;
  bit pend;
  string pend_tag;

  alu_cc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .alu_fn(alu_fn),
    .set_cc(set_cc), .jmp_fn(jmp_fn), .result(result), .flag_zero(flag_zero),
    .flag_sign(flag_sign), .flag_ovf(flag_ovf), .take_branch(take_branch)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_op(input bit [31:0] a, input bit [31:0] b, input bit [1:0] f,
                          output bit [31:0] r, output bit z, output bit s, output bit o);
    longint sa, sb, w;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    o = 0;
    case (f)
      2'd0: begin w = sb + sa; r = w[31:0]; o = (w > 64'sd2147483647) || (w < -64'sd2147483648); end
      2'd1: begin w = sb - sa; r = w[31:0]; o = (w > 64'sd2147483647) || (w < -64'sd2147483648); end
      2'd2: r = a & b;
      default: r = a ^ b;
    endcase
    z = (r == 0);
    s = r[31];
  endtask

  function automatic bit model_br(input bit [3:0] j);
    bit lt;
    lt = (m_s != m_o);
    case (j)
      4'd0: return 1;
      4'd1: return lt || m_z;
      4'd2: return lt;
      4'd3: return m_z;
      4'd4: return !m_z;
      4'd5: return !lt;
      4'd6: return !lt && !m_z;
      default: return 0;
    endcase
  endfunction

  task automatic check_flags();
    chk({pend_tag, " R2 zero"}, flag_zero, m_z);
    chk({pend_tag, " R2 sign"}, flag_sign, m_s);
    chk({pend_tag, " ovf"}, flag_ovf, m_o);
  endtask

  // one cycle: check flags from last edge, drive, check comb outputs, take edge
  task automatic step(input bit [31:0] a, input bit [31:0] b, input bit [1:0] f,
                      input bit s, input bit [3:0] j);
    bit [31:0] r;
    bit z, sg, o;
    @(negedge clk);
    check_flags();
    op_a = a; op_b = b; alu_fn = f; set_cc = s; jmp_fn = j;
    #5;
    model_op(a, b, f, r, z, sg, o);
    chk("R1 result", result, r);
    chk(j > 6 ? "R9 branch" : (s ? "R10 R8 branch" : "R8 branch"), take_branch, model_br(j));
    @(posedge clk);
    if (s) begin
      m_z = z; m_s = sg; m_o = o;
      pend_tag = (f == 0) ? "R3" : (f == 1) ? "R4" : "R5";
    end else begin
      pend_tag = "R6";
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_a = 0; op_b = 0; alu_fn = 0; set_cc = 0; jmp_fn = 0;
    m_z = 1; m_s = 0; m_o = 0; pend_tag = "R7";
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 zero", flag_zero, 1);
    chk("R7 sign", flag_sign, 0);
    chk("R7 ovf", flag_ovf, 0);
    // R7: flags stay at reset value while the release is being synchronised
    rst_n = 1'b1;
    op_a = 32'h5; op_b = 32'h7; set_cc = 1;
    @(posedge clk); @(negedge clk);
    chk("R7 hold after release", flag_zero, 1);
    set_cc = 0;
    repeat (3) @(negedge clk);
    pend_tag = "R7";

    // R1/R4 subtract order: 10 - 3
    step(32'd3, 32'd10, 2'd1, 1, 4'd0);
    // R3 add overflow positive
    step(32'h0000_0001, 32'h7fff_ffff, 2'd0, 1, 4'd2);
    // R4 subtract overflow: 0x80000000 - 1
    step(32'h0000_0001, 32'h8000_0000, 2'd1, 1, 4'd2);
    // R3 add overflow negative
    step(32'h8000_0000, 32'h8000_0000, 2'd0, 1, 4'd1);
    // R5 AND clears overflow, result zero
    step(32'hf0f0_0000, 32'h0f0f_ffff, 2'd2, 1, 4'd5);
    // R10: zero flag set, new op makes nonzero, je evaluated same cycle
    step(32'h1234_5678, 32'h0000_0001, 2'd3, 1, 4'd3);
    // R6 hold: an overflowing add with set_cc low
    step(32'h7fff_ffff, 32'h7fff_ffff, 2'd0, 0, 4'd4);
    // R4 no overflow when signs equal
    step(32'hffff_fffe, 32'hffff_ffff, 2'd1, 1, 4'd6);
    // zero via subtract of equal operands
    step(32'd77, 32'd77, 2'd1, 1, 4'd6);
    // R8 / R9 sweep of all codes on current flags
    for (int j = 0; j < 16; j++) step(32'd0, 32'd0, 2'd0, 0, j[3:0]);
    // negative sign, no overflow, sweep
    step(32'd5, 32'd2, 2'd1, 1, 4'd0);
    for (int j = 0; j < 16; j++) step(32'd0, 32'd0, 2'd0, 0, j[3:0]);
    // overflow with positive-looking sign, sweep
    step(32'h0000_0001, 32'h8000_0000, 2'd1, 1, 4'd0);
    for (int j = 0; j < 16; j++) step(32'd0, 32'd0, 2'd0, 0, j[3:0]);
    // random mix
    for (int i = 0; i < 400; i++) begin
      bit [31:0] ra, rb;
      ra = $urandom;
      rb = ($urandom_range(0, 7) == 0) ? ra : $urandom;
      if ($urandom_range(0, 5) == 0) begin ra[31] = 1'b0; rb[31] = 1'b0; ra[30] = 1'b1; rb[30] = 1'b1; end
      step(ra, rb, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
    end
    @(negedge clk);
    check_flags();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule